// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block receives bytes carried in a time-division monitor channel and acknowledges each one with a handshake that advances once per frame. A frame timer outside the block pulses `frame_strobe` once per frame. On that cycle the channel byte and the transmitter's active-low valid bit are presented to the block. The channel idles at all ones, with both handshake bits inactive (1). One handshake step takes one frame (125 µs in the intended system).

A byte counts as received only when the same value appears in two consecutive frames with the valid bit low. The first byte of a message is always stored and signalled, whatever the receive-enable input is set to. Software can therefore inspect that byte, for example as a destination address, before it commits to the message by raising `rcv_en`.

While `rcv_en` is high, later bytes are stored and acknowledged by driving `ack_n` low. The acknowledge is released when the valid bit returns high. Two consecutive frames with the valid bit high during a message mark its end, and the block raises a one-cycle end-of-message pulse. Software then lowers `rcv_en`.

The controller has five states:
- IDLE: no message is in progress.
- HOLD: the first byte has been taken and is awaiting enable.
- ACK: the acknowledge is being driven.
- GAP: one idle frame has been seen inside a message.
- RECV: data frames are arriving but no byte has been accepted yet.

Transitions, all taken only on a frame strobe:
- IDLE→HOLD on a match.
- HOLD→ACK when enabled.
- HOLD→GAP on an idle frame.
- ACK→GAP on an idle frame.
- GAP→IDLE on a second idle frame, which raises end of message.
- GAP→ACK on an accepted byte.
- GAP→RECV on any other data frame.
- RECV→ACK on an accepted byte.
- RECV→GAP on an idle frame.

Top module: `mon_byte_rx`

## Requirements
- R1: A byte is accepted only when `frame_strobe` finds `valid_n`=0 with the same `mon_byte` value in two consecutive frames. A single sighting, or differing values in consecutive frames, is not accepted.
- R2: The first accepted byte of a message is stored in `rx_data` and raises `data_irq`, even when `rcv_en`=0.
- R3: After the first byte, while `rcv_en`=0, `ack_n` stays 1 and no further byte is stored or signalled.
- R4: When `rcv_en`=1, `ack_n` goes to 0 after the strobe that accepts a byte, or after the strobe that finds the held first byte with enable set. It returns to 1 after the next strobe with `valid_n`=1.
- R5: `data_irq` is a one-cycle pulse in the cycle after the accepting strobe, one pulse per accepted byte. `rx_data` updates in that same cycle and holds its value otherwise.
- R6: During a message, two consecutive strobes with `valid_n`=1 produce a one-cycle `eom_irq` in the cycle after the second strobe and return the block to IDLE. A single idle frame between bytes does not end the message.
- R7: Reset (`rst_n`=0, asynchronous) gives `ack_n`=1, `rx_data`=0, `data_irq`=0, `eom_irq`=0 and the IDLE state.
- R8: `valid_n` and `mon_byte` have no effect in cycles without `frame_strobe`.
- R9: A byte that keeps repeating while it is being acknowledged is stored and signalled only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-cycle pulse per frame marking the channel slot |
| valid_n | input | 1 | Transmitter valid bit, active low |
| mon_byte | input | W | Channel byte in this frame |
| rcv_en | input | 1 | Software receive enable |
| ack_n | output | 1 | Acknowledge bit to the transmitter, active low |
| rx_data | output | W | Last accepted byte |
| data_irq | output | 1 | One-cycle pulse per accepted byte |
| eom_irq | output | 1 | One-cycle end-of-message pulse |

## Verification
The assertions take for granted that frame strobes are at least two cycles apart, so a pulse is never stretched by a following strobe. They also assume `rcv_en` changes only between strobes. The bench produces a strobe every four cycles, and changes `rcv_en` and the slot inputs only one time unit after a rising edge. Between strobes it drives `valid_n` and `mon_byte` with garbage, so the fact that non-strobe cycles are ignored is exercised continuously.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ACK,
        ST_GAP,
        ST_RECV
    } rx_state_t;
endpackage

// File: rtl/mon_rx_match.sv
module mon_rx_match #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_strobe,
    input  logic         valid_n,
    input  logic [W-1:0] mon_byte,
    output logic         match
);
    logic [W-1:0] cand_q;
    logic         cand_vld_q;

    // Candidate from the previous frame: kept only while valid stays low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q     <= '0;
            cand_vld_q <= 1'b0;
        end else if (frame_strobe) begin
            if (valid_n) begin
                cand_vld_q <= 1'b0;
            end else begin
                cand_vld_q <= 1'b1;
                cand_q     <= mon_byte;
            end
        end
    end

    always_comb begin
        match = frame_strobe && !valid_n && cand_vld_q && (mon_byte == cand_q);
    end
endmodule

// File: rtl/mon_rx_fsm.sv
module mon_rx_fsm
    import mon_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_strobe,
    input  logic      valid_n,
    input  logic      match,
    input  logic      rcv_en,
    output logic      store,
    output logic      eom,
    output logic      ack_n,
    output rx_state_t state
);
    rx_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (frame_strobe) begin
            unique case (state_q)
                ST_IDLE: if (match) state_d = ST_HOLD;
                ST_HOLD: begin
                    if (valid_n)     state_d = ST_GAP;
                    else if (rcv_en) state_d = ST_ACK;
                end
                ST_ACK:  if (valid_n) state_d = ST_GAP;
                ST_GAP: begin
                    if (valid_n)              state_d = ST_IDLE;
                    else if (match && rcv_en) state_d = ST_ACK;
                    else                      state_d = ST_RECV;
                end
                ST_RECV: begin
                    if (valid_n)              state_d = ST_GAP;
                    else if (match && rcv_en) state_d = ST_ACK;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        store = 1'b0;
        eom   = 1'b0;
        unique case (state_q)
            ST_IDLE:         store = match;
            ST_GAP, ST_RECV: begin
                store = match && rcv_en;
                eom   = frame_strobe && valid_n && (state_q == ST_GAP);
            end
            default: ;
        endcase
        ack_n = !((state_q == ST_ACK) && rcv_en);
        state = state_q;
    end

    // R8
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(state_q));
endmodule

// File: rtl/mon_rx_out.sv
module mon_rx_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         store,
    input  logic         eom,
    input  logic [W-1:0] mon_byte,
    output logic [W-1:0] rx_data,
    output logic         data_irq,
    output logic         eom_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            data_irq <= 1'b0;
            eom_irq  <= 1'b0;
        end else begin
            data_irq <= store;
            eom_irq  <= eom;
            if (store) rx_data <= mon_byte;
        end
    end
endmodule

// File: rtl/mon_byte_rx.sv
module mon_byte_rx
    import mon_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_strobe,
    input  logic         valid_n,
    input  logic [W-1:0] mon_byte,
    input  logic         rcv_en,
    output logic         ack_n,
    output logic [W-1:0] rx_data,
    output logic         data_irq,
    output logic         eom_irq
);
    logic      match, store, eom;
    rx_state_t fsm_state;

    mon_rx_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .valid_n(valid_n), .mon_byte(mon_byte), .match(match)
    );

    mon_rx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .valid_n(valid_n), .match(match), .rcv_en(rcv_en),
        .store(store), .eom(eom), .ack_n(ack_n), .state(fsm_state)
    );

    mon_rx_out #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .store(store), .eom(eom),
        .mon_byte(mon_byte), .rx_data(rx_data),
        .data_irq(data_irq), .eom_irq(eom_irq)
    );

    // R1
    data_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_irq |-> $past(frame_strobe && !valid_n));
    // R5
    data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_irq |=> !data_irq);
    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_irq |-> $stable(rx_data));
    // R6
    eom_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_irq |-> $past(frame_strobe && valid_n));
    // R3
    later_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_irq && !$past(rcv_en)) |-> $past(fsm_state == ST_IDLE));
    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_n) && rcv_en && $past(rcv_en)) |-> $past(frame_strobe && valid_n));
endmodule

// File: tb/mon_byte_rx_test.sv
module mon_byte_rx_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_strobe = 1'b0;
    logic         valid_n = 1'b1;
    logic [W-1:0] mon_byte = '1;
    logic         rcv_en = 1'b0;
    logic         ack_n;
    logic [W-1:0] rx_data;
    logic         data_irq, eom_irq;

    int errors = 0;
    int checks = 0;
    int data_cnt = 0;
    int eom_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mon_byte_rx #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .valid_n(valid_n), .mon_byte(mon_byte), .rcv_en(rcv_en),
        .ack_n(ack_n), .rx_data(rx_data), .data_irq(data_irq), .eom_irq(eom_irq)
    );

    // Behavioural reference model
    bit         in_msg = 0, holding = 0, acking = 0, have_last = 0;
    int         idle_run = 0;
    logic [W-1:0] last = '0;
    logic [W-1:0] exp_rx = '0;
    bit         exp_dirq = 0, exp_eom = 0;

    always @(posedge clk) begin
        bit seen;
        exp_dirq = 0;
        exp_eom  = 0;
        if (!rst_n) begin
            in_msg = 0; holding = 0; acking = 0; have_last = 0;
            idle_run = 0; exp_rx = '0;
        end else if (frame_strobe) begin
            seen = !valid_n && have_last && (mon_byte == last);
            if (valid_n) have_last = 0;
            else begin have_last = 1; last = mon_byte; end
            if (!in_msg) begin
                if (seen) begin
                    exp_rx = mon_byte; exp_dirq = 1;
                    in_msg = 1; holding = 1; acking = 0; idle_run = 0;
                end
            end else if (valid_n) begin
                if (holding || acking) begin
                    holding = 0; acking = 0; idle_run = 1;
                end else if (idle_run >= 1) begin
                    exp_eom = 1; in_msg = 0; idle_run = 0;
                end else idle_run = 1;
            end else begin
                idle_run = 0;
                if (holding) begin
                    if (rcv_en) begin holding = 0; acking = 1; end
                end else if (!acking && seen && rcv_en) begin
                    exp_rx = mon_byte; exp_dirq = 1; acking = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(ack_n == !(acking && rcv_en), "R4 ack_n", ack_n, !(acking && rcv_en));
            chk(rx_data == exp_rx, "R5 rx_data", rx_data, exp_rx);
            chk(data_irq == exp_dirq, "R1 data_irq", data_irq, exp_dirq);
            chk(eom_irq == exp_eom, "R6 eom_irq", eom_irq, exp_eom);
            if (data_irq) data_cnt++;
            if (eom_irq) eom_cnt++;
        end
    end

    // One frame: strobe cycle, then three cycles of garbage on the slot (R8)
    task automatic frame(input bit v_n, input logic [W-1:0] b);
        @(posedge clk); #1;
        frame_strobe = 1; valid_n = v_n; mon_byte = b;
        @(posedge clk); #1;
        frame_strobe = 0; valid_n = ~v_n; mon_byte = 8'h5A;
        @(posedge clk); #1;
        mon_byte = b ^ 8'hFF;
        @(posedge clk); #1;
        valid_n = 0; mon_byte = b;
    endtask

    task automatic set_en(input bit e);
        @(posedge clk); #1; rcv_en = e;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        chk(ack_n == 1'b1, "R7 ack_n reset", ack_n, 1);
        chk(rx_data == '0, "R7 rx_data reset", rx_data, 0);
        chk(!data_irq && !eom_irq, "R7 irqs reset", {data_irq, eom_irq}, 0);
        @(posedge clk); #1; rst_n = 1;

        // Message with software gating on the first byte
        frame(1, 8'hFF); frame(1, 8'hFF);
        frame(0, 8'h21); frame(0, 8'h21);
        frame(0, 8'h21); frame(0, 8'h21); frame(0, 8'h21);
        chk(data_cnt == 1, "R2 first byte with rcv_en=0", data_cnt, 1);
        chk(rx_data == 8'h21, "R2 first byte value", rx_data, 8'h21);
        chk(ack_n == 1'b1, "R3 no ack while disabled", ack_n, 1);
        set_en(1);
        frame(0, 8'h21); frame(0, 8'h21);
        chk(ack_n == 1'b0, "R4 ack driven after enable", ack_n, 0);
        frame(1, 8'hFF);
        chk(ack_n == 1'b1, "R4 ack released", ack_n, 1);
        frame(0, 8'h3C); frame(0, 8'h3C); frame(0, 8'h3C); frame(0, 8'h3C);
        chk(data_cnt == 2, "R9 repeated byte stored once", data_cnt, 2);
        frame(1, 8'hFF);
        chk(eom_cnt == 0, "R6 single idle not end", eom_cnt, 0);
        frame(0, 8'hC7); frame(0, 8'hC7); frame(0, 8'hC7);
        frame(1, 8'hFF); frame(1, 8'hFF);
        chk(eom_cnt == 1, "R6 end of message", eom_cnt, 1);
        chk(data_cnt == 3, "R5 one pulse per byte", data_cnt, 3);
        chk(rx_data == 8'hC7, "R5 last byte", rx_data, 8'hC7);
        set_en(0);

        // Message never enabled: only the first byte is kept
        frame(0, 8'h44); frame(0, 8'h44); frame(1, 8'hFF);
        frame(0, 8'h91); frame(0, 8'h91); frame(0, 8'h91);
        chk(data_cnt == 4, "R3 later byte not stored", data_cnt, 4);
        chk(rx_data == 8'h44, "R3 rx_data kept", rx_data, 8'h44);
        frame(1, 8'hFF); frame(1, 8'hFF);
        chk(eom_cnt == 2, "R6 end without enable", eom_cnt, 2);

        // Unstable byte never accepted
        set_en(1);
        frame(0, 8'h10); frame(0, 8'h20); frame(0, 8'h10); frame(0, 8'h20);
        chk(data_cnt == 4, "R1 differing bytes rejected", data_cnt, 4);
        frame(1, 8'hFF); frame(0, 8'h55); frame(1, 8'hFF);
        chk(data_cnt == 4, "R1 single sighting rejected", data_cnt, 4);
        frame(1, 8'hFF);
        chk(eom_cnt == 2, "R8 no message no end", eom_cnt, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule